// File: doc/BRIEF.md
# Video Acquisition Window Generator

The block cuts a rectangular acquisition window out of a video stream clocked at the pixel rate. A pixel counter restarts on each horizontal reference edge and a line counter restarts on each vertical reference edge. The window opens once a programmed number of source pixels and source lines has gone by. It closes when a programmed number of destination pixels and destination lines has been handed out. No scaling is done here, so each pixel accepted inside the window is one destination pixel.

Two sources feed it. In decoder mode every clock cycle that is not a reference edge is a source pixel, and every line counts. In external-port mode only cycles with the pixel qualifier high are pixels, and a line advances the line counter only if it carried at least one qualified pixel. The source select and all six 12-bit size and offset values are copied into shadow registers at the vertical reference edge, so the window shape stays fixed for a whole field.

A vertical state machine tracks each field. Its states are `VS_IDLE` (no vertical edge seen since reset), `VS_WAIT` (field started, no line yet), `VS_PRE` (line above the vertical offset), `VS_OPEN` (line inside the window) and `VS_DONE` (window used up for this field). A vertical edge moves any state to `VS_WAIT`. A horizontal edge moves `VS_WAIT`, `VS_PRE` or `VS_OPEN` to whichever of `VS_PRE`, `VS_OPEN` or `VS_DONE` fits the new line number. `VS_DONE` holds until the next vertical edge, and `VS_IDLE` ignores horizontal edges.

Top module: `vid_acq_window`

## Requirements
- R1: After reset `pix_valid` and `line_valid` are 0 and `pix_idx` and `line_idx` are 0. No output goes high until the first vertical reference edge.
- R2: In decoder mode (`src_ext`=0) every non-edge cycle after a horizontal edge is a source pixel, numbered from 0. A pixel inside the window drives `pix_valid`=1 one cycle later, with `pix_idx` = source pixel number minus the horizontal offset.
- R3: The horizontal window admits source pixels from `h_off` up to but excluding `h_off` + min(`h_src_len`, `h_dst_size`).
- R4: The first horizontal edge after a vertical edge starts line 0. `line_valid` changes only in the cycle after a horizontal or vertical edge. While `line_valid` is 1, `line_idx` = line number minus `v_off`.
- R5: `pix_valid` is 1 only while `line_valid` is 1.
- R6: The vertical window admits lines from `v_off` up to but excluding `v_off` + min(`v_src_len`, `v_dst_size`), and `line_idx` stays below `v_dst_size`.
- R7: A vertical edge closes the window in the next cycle (`line_valid`=0, `pix_valid`=0), even if fewer lines than expected have arrived.
- R8: In external-port mode (`src_ext`=1) only cycles with `pix_qual`=1 are pixels, so `pix_idx` counts qualified pixels only. A line with no qualified pixel does not advance the line number.
- R9: `h_fall`/`v_fall` select the reference edge: 0 for a rising edge of `h_sync`/`v_sync`, 1 for a falling edge.
- R10: Offsets, lengths, destination sizes and `src_ext` are captured at the vertical edge. Changing them during a field has no effect until the next vertical edge.
- R11: A zero horizontal length or zero horizontal destination size gives no `pix_valid` for the field. A zero vertical length or zero vertical destination size gives neither `line_valid` nor `pix_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_ext | input | 1 | Source select: 0 decoder path, 1 external port |
| pix_qual | input | 1 | Pixel qualifier strobe (external-port mode) |
| h_sync | input | 1 | Horizontal reference signal |
| v_sync | input | 1 | Vertical reference signal |
| h_fall | input | 1 | 1 selects the falling edge of `h_sync` as reference |
| v_fall | input | 1 | 1 selects the falling edge of `v_sync` as reference |
| h_off | input | W | Horizontal offset in source pixels |
| h_src_len | input | W | Horizontal length in source pixels |
| h_dst_size | input | W | Horizontal destination size in pixels |
| v_off | input | W | Vertical offset in source lines |
| v_src_len | input | W | Vertical length in source lines |
| v_dst_size | input | W | Vertical destination size in lines |
| pix_valid | output | 1 | Current output pixel lies in the window |
| line_valid | output | 1 | Current line lies in the window |
| pix_idx | output | W | Index of the pixel within the window |
| line_idx | output | W | Index of the line within the window |

## Verification
The bench builds the block with the default width W=12. It programs offsets and sizes of a few units so that a whole field of a handful of short lines fits in a few hundred cycles. With such small values, both the source-length limit and the destination-size limit can be made the binding one on each axis. Small values also let the bench reach zero sizes, a field cut short by an early vertical edge, and a register change in mid-field. External-port lines mix fully qualified, alternately qualified and unqualified pixels, which checks both compacted pixel numbering and lines that do not advance the line number.

// File: rtl/acq_pkg.sv
package acq_pkg;

    // Vertical tracking states of one field
    typedef enum logic [2:0] {
        VS_IDLE = 3'd0,
        VS_WAIT = 3'd1,
        VS_PRE  = 3'd2,
        VS_OPEN = 3'd3,
        VS_DONE = 3'd4
    } vstate_e;

endpackage

// File: rtl/acq_edge_det.sv
module acq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic fall_sel,
    output logic edge_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    // Edge flagged in the cycle the input takes its new level
    always_comb begin
        edge_o = fall_sel ? (sig_q & ~sig_i) : (~sig_q & sig_i);
    end
endmodule

// File: rtl/acq_hwin.sv
module acq_hwin #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         h_edge,
    input  logic         v_edge,
    input  logic         pix_acc,
    input  logic         line_open,
    input  logic [W-1:0] h_off,
    input  logic [W-1:0] h_len,
    input  logic [W-1:0] h_dst,
    output logic         pix_valid,
    output logic [W-1:0] pix_idx
);
    logic [W-1:0] sx_q;
    logic [W-1:0] rel;
    logic [W:0]   h_end;
    logic         in_win;

    always_comb begin
        rel    = sx_q - h_off;
        h_end  = {1'b0, h_off} + {1'b0, h_len};
        in_win = pix_acc && line_open && (sx_q >= h_off)
                 && ({1'b0, sx_q} < h_end) && (rel < h_dst);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sx_q      <= '0;
            pix_valid <= 1'b0;
            pix_idx   <= '0;
        end else begin
            if (h_edge || v_edge)            sx_q <= '0;
            else if (pix_acc && sx_q != '1)  sx_q <= sx_q + 1'b1;
            pix_valid <= in_win;
            if (in_win) pix_idx <= rel;
        end
    end
endmodule

// File: rtl/acq_vfsm.sv
module acq_vfsm
    import acq_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_edge,
    input  logic         h_edge,
    input  logic         line_hit,
    input  logic [W-1:0] v_off,
    input  logic [W-1:0] v_len,
    input  logic [W-1:0] v_dst,
    output logic         line_open,
    output logic [W-1:0] line_idx
);
    vstate_e      st_q, st_d;
    logic [W-1:0] sy_q, sy_d;
    logic [W-1:0] ny;
    logic [W-1:0] rel;
    logic [W:0]   v_end;
    vstate_e      cls;

    // Line number the next line will carry, and its window class
    always_comb begin
        if (st_q == VS_WAIT)              ny = '0;
        else if (line_hit && sy_q != '1)  ny = sy_q + 1'b1;
        else                              ny = sy_q;
        rel   = ny - v_off;
        v_end = {1'b0, v_off} + {1'b0, v_len};
        if (ny < v_off)                                  cls = VS_PRE;
        else if (({1'b0, ny} < v_end) && (rel < v_dst))  cls = VS_OPEN;
        else                                             cls = VS_DONE;
    end

    always_comb begin
        st_d = st_q;
        sy_d = sy_q;
        if (v_edge) begin
            st_d = VS_WAIT;
            sy_d = '0;
        end else if (h_edge) begin
            unique case (st_q)
                VS_IDLE: st_d = VS_IDLE;
                VS_WAIT, VS_PRE, VS_OPEN: begin
                    st_d = cls;
                    sy_d = ny;
                end
                VS_DONE: begin
                    st_d = VS_DONE;
                    sy_d = ny;
                end
                default: st_d = VS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= VS_IDLE;
            sy_q <= '0;
        end else begin
            st_q <= st_d;
            sy_q <= sy_d;
        end
    end

    always_comb begin
        line_open = (st_q == VS_OPEN);
        line_idx  = sy_q - v_off;
    end
endmodule

// File: rtl/vid_acq_window.sv
module vid_acq_window #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_ext,
    input  logic         pix_qual,
    input  logic         h_sync,
    input  logic         v_sync,
    input  logic         h_fall,
    input  logic         v_fall,
    input  logic [W-1:0] h_off,
    input  logic [W-1:0] h_src_len,
    input  logic [W-1:0] h_dst_size,
    input  logic [W-1:0] v_off,
    input  logic [W-1:0] v_src_len,
    input  logic [W-1:0] v_dst_size,
    output logic         pix_valid,
    output logic         line_valid,
    output logic [W-1:0] pix_idx,
    output logic [W-1:0] line_idx
);
    logic         h_edge, v_edge;
    logic         sh_ext;
    logic [W-1:0] sh_hoff, sh_hlen, sh_hdst, sh_voff, sh_vlen, sh_vdst;
    logic         seen_q, pix_acc, line_hit, line_open;

    acq_edge_det u_hedge (.clk(clk), .rst_n(rst_n), .sig_i(h_sync),
                          .fall_sel(h_fall), .edge_o(h_edge));
    acq_edge_det u_vedge (.clk(clk), .rst_n(rst_n), .sig_i(v_sync),
                          .fall_sel(v_fall), .edge_o(v_edge));

    // Field-stable copies of the window settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_ext  <= 1'b0;
            sh_hoff <= '0; sh_hlen <= '0; sh_hdst <= '0;
            sh_voff <= '0; sh_vlen <= '0; sh_vdst <= '0;
        end else if (v_edge) begin
            sh_ext  <= src_ext;
            sh_hoff <= h_off; sh_hlen <= h_src_len; sh_hdst <= h_dst_size;
            sh_voff <= v_off; sh_vlen <= v_src_len; sh_vdst <= v_dst_size;
        end
    end

    always_comb begin
        pix_acc  = !h_edge && !v_edge && (sh_ext ? pix_qual : 1'b1);
        line_hit = sh_ext ? seen_q : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                seen_q <= 1'b0;
        else if (h_edge || v_edge) seen_q <= 1'b0;
        else if (pix_acc)          seen_q <= 1'b1;
    end

    acq_vfsm #(.W(W)) u_vfsm (
        .clk(clk), .rst_n(rst_n), .v_edge(v_edge), .h_edge(h_edge),
        .line_hit(line_hit), .v_off(sh_voff), .v_len(sh_vlen), .v_dst(sh_vdst),
        .line_open(line_open), .line_idx(line_idx)
    );

    acq_hwin #(.W(W)) u_hwin (
        .clk(clk), .rst_n(rst_n), .h_edge(h_edge), .v_edge(v_edge),
        .pix_acc(pix_acc), .line_open(line_open),
        .h_off(sh_hoff), .h_len(sh_hlen), .h_dst(sh_hdst),
        .pix_valid(pix_valid), .pix_idx(pix_idx)
    );

    always_comb line_valid = line_open;
endmodule

// File: rtl/acq_window_checks.sv
module acq_window_checks #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         h_edge,
    input logic         v_edge,
    input logic         pix_valid,
    input logic         line_valid,
    input logic [W-1:0] pix_idx,
    input logic [W-1:0] line_idx,
    input logic [W-1:0] sh_hdst,
    input logic [W-1:0] sh_vdst
);
    a_r5_pix_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> line_valid);

    a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid)) |-> (pix_idx == $past(pix_idx) + 1'b1));

    a_r3_hdst_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_idx < sh_hdst));

    a_r6_vdst_bound: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_idx < sh_vdst));

    a_r7_vedge_close: assert property (@(posedge clk) disable iff (!rst_n)
        v_edge |=> (!line_valid && !pix_valid));

    a_r4_line_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_edge && !v_edge) |=> $stable(line_valid));
endmodule

bind vid_acq_window acq_window_checks #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .h_edge(h_edge), .v_edge(v_edge),
    .pix_valid(pix_valid), .line_valid(line_valid),
    .pix_idx(pix_idx), .line_idx(line_idx),
    .sh_hdst(sh_hdst), .sh_vdst(sh_vdst)
);

// File: tb/vid_acq_window_bench.sv
`timescale 1ns/1ps
module vid_acq_window_bench;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_ext = 1'b0, pix_qual = 1'b0;
    logic h_sync = 1'b0, v_sync = 1'b0, h_fall = 1'b0, v_fall = 1'b0;
    logic [W-1:0] h_off = '0, h_src_len = '0, h_dst_size = '0;
    logic [W-1:0] v_off = '0, v_src_len = '0, v_dst_size = '0;
    logic         pix_valid, line_valid;
    logic [W-1:0] pix_idx, line_idx;

    always #4 clk = ~clk;

    vid_acq_window #(.W(W)) u_vid_acq_window (
        .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .pix_qual(pix_qual),
        .h_sync(h_sync), .v_sync(v_sync), .h_fall(h_fall), .v_fall(v_fall),
        .h_off(h_off), .h_src_len(h_src_len), .h_dst_size(h_dst_size),
        .v_off(v_off), .v_src_len(v_src_len), .v_dst_size(v_dst_size),
        .pix_valid(pix_valid), .line_valid(line_valid),
        .pix_idx(pix_idx), .line_idx(line_idx)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [23:0] exp_q[$];

    // Reference model state
    bit m_started = 0, m_first = 0, m_hit = 0, m_ext = 0;
    int m_cur = 0;
    int s_ho, s_hl, s_hd, s_vo, s_vl, s_vd;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    function automatic bit qbit(input int k, input int mode);
        if (mode == 0) return 1'b1;
        if (mode == 1) return (k % 2) == 1;
        return 1'b0;
    endfunction

    // Monitor: pop one expected item per valid output pixel
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected pix_valid, pix_idx", pix_idx, -1);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check(pix_idx == e[11:0], "R3 pix_idx", pix_idx, e[11:0]);
                check(line_idx == e[23:12], "R6 line_idx with pixel", line_idx, e[23:12]);
            end
        end
    end

    task automatic pulse_v();
        v_sync = v_fall ? 1'b0 : 1'b1;
        pix_qual = 1'b0;
        m_started = 1; m_first = 1; m_hit = 0; m_ext = src_ext;
        s_ho = h_off; s_hl = h_src_len; s_hd = h_dst_size;
        s_vo = v_off; s_vl = v_src_len; s_vd = v_dst_size;
        tick();
        v_sync = v_fall ? 1'b1 : 1'b0;
        @(negedge clk);
        check(line_valid == 1'b0, "R7 line_valid after vertical edge", line_valid, 0);
        check(pix_valid == 1'b0, "R7 pix_valid after vertical edge", pix_valid, 0);
        check(exp_q.size() == 0, "R7 expected pixels all delivered", exp_q.size(), 0);
        tick();
    endtask

    task automatic send_line(input int npix, input int mode);
        bit open = 0;
        bit hit = 0;
        int sx = 0;
        if (m_started) begin
            if (m_first) m_cur = 0;
            else if (!m_ext || m_hit) m_cur = (m_cur == 4095) ? 4095 : m_cur + 1;
            m_first = 0;
            open = (m_cur >= s_vo) && (m_cur < s_vo + s_vl) && (m_cur - s_vo < s_vd);
            for (int k = 0; k < npix; k++) begin
                if (!m_ext || qbit(k, mode)) begin
                    hit = 1;
                    if (open && sx >= s_ho && sx < s_ho + s_hl && sx - s_ho < s_hd)
                        exp_q.push_back({12'(m_cur - s_vo), 12'(sx - s_ho)});
                    sx++;
                end
            end
            m_hit = hit;
        end
        h_sync = h_fall ? 1'b0 : 1'b1;
        pix_qual = 1'b0;
        tick();
        h_sync = h_fall ? 1'b1 : 1'b0;
        for (int k = 0; k < npix; k++) begin
            pix_qual = qbit(k, mode);
            if (k == 0) begin
                @(negedge clk);
                check(line_valid == open, "R4 line_valid after horizontal edge", line_valid, open);
                if (open)
                    check(line_idx == W'(m_cur - s_vo), "R4 line_idx", line_idx, m_cur - s_vo);
            end
            tick();
        end
    endtask

    task automatic set_win(input int ho, hl, hd, vo, vl, vd);
        h_off = W'(ho); h_src_len = W'(hl); h_dst_size = W'(hd);
        v_off = W'(vo); v_src_len = W'(vl); v_dst_size = W'(vd);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check(pix_valid == 0 && line_valid == 0, "R1 reset flags", pix_valid + line_valid, 0);
        check(pix_idx == 0 && line_idx == 0, "R1 reset indices", pix_idx + line_idx, 0);
        rst_n = 1'b1;
        tick();

        // R1: lines before any vertical edge produce nothing
        set_win(0, 8, 8, 0, 4, 4);
        for (int i = 0; i < 3; i++) send_line(6, 0);

        // R2/R3/R6: decoder field, source length binds
        set_win(3, 6, 10, 2, 3, 5);
        pulse_v();
        for (int i = 0; i < 7; i++) send_line(12, 0);

        // R3/R6: destination sizes bind
        set_win(2, 8, 4, 1, 5, 2);
        pulse_v();
        for (int i = 0; i < 6; i++) send_line(12, 0);

        // R8: external port, mixed qualification
        src_ext = 1'b1;
        set_win(1, 5, 5, 1, 4, 4);
        pulse_v();
        send_line(10, 0); send_line(10, 1); send_line(10, 2); send_line(10, 1);
        send_line(10, 0); send_line(10, 2); send_line(10, 1); send_line(10, 0);
        src_ext = 1'b0;

        // R7: field cut short by an early vertical edge
        set_win(0, 6, 6, 0, 10, 10);
        pulse_v();
        for (int i = 0; i < 3; i++) send_line(8, 0);

        // R10: mid-field register changes take no effect
        set_win(2, 4, 4, 1, 3, 3);
        pulse_v();
        send_line(9, 0); send_line(9, 0);
        set_win(5, 1, 1, 0, 1, 1);
        src_ext = 1'b1;
        send_line(9, 0); send_line(9, 0); send_line(9, 0);
        src_ext = 1'b0;

        // R11: zero horizontal destination, zero horizontal length, zero vertical length
        set_win(1, 5, 0, 0, 3, 3);
        pulse_v();
        for (int i = 0; i < 3; i++) send_line(8, 0);
        set_win(1, 0, 5, 0, 3, 3);
        pulse_v();
        for (int i = 0; i < 3; i++) send_line(8, 0);
        set_win(0, 5, 5, 0, 0, 3);
        pulse_v();
        for (int i = 0; i < 3; i++) send_line(8, 0);

        // R9: falling reference edges
        h_fall = 1'b1; v_fall = 1'b1;
        tick();
        h_sync = 1'b1; v_sync = 1'b1;
        tick();
        set_win(1, 4, 4, 1, 2, 2);
        pulse_v();
        for (int i = 0; i < 4; i++) send_line(7, 0);
        pulse_v();
        check(n_cmp > 60, "R9 enough comparisons made", n_cmp, 61);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule